// File: doc/BRIEF.md
# Operand Addressing and Fetch Unit

This unit turns the operand fields of one decoded instruction into an operand value on a 16-bit word machine. It takes a format selector, the register index field, a memory-reference flag, an indirect flag, the low byte of the first instruction word and the second instruction word. From these it picks one of eight addressing modes. It reads a register through a combinational read port, and it reads data memory through a request/valid handshake with as many wait cycles as memory needs.

Three kinds of mode need no memory access: short constant, register, and long constant. All three finish one cycle after the start request. Register-indirect, direct and indexed modes make one memory read. Indirect and indexed-indirect modes make two reads in sequence. In those two modes any indexing is applied to the pointer location before the pointer is read, and the pointer is then used unchanged. The unit returns the operand, the effective address and a one-cycle done strobe. The effective address is zero for modes that do not reference memory.

Top module: `opnd_resolve`

## Requirements
- R1: With format code 2'b00 (short constant), the operand is the instruction low byte zero-extended to 16 bits. The effective address is 0 and no memory read occurs. The register field and flags have no effect.
- R2: With format code 2'b01 (short), the operand is the value of register `r2_i` when the memory flag is 0 or `r2_i` is 0. The effective address is 0 and no memory read occurs.
- R3: With a format code whose upper bit is 1 (long) and the memory flag at 0, the operand is the full second word. The effective address is 0 and no read occurs, whatever the values of `r2_i` and the indirect flag.
- R4: With format 2'b01, the memory flag at 1 and `r2_i` nonzero, exactly one read is made at the address held in register `r2_i`. The data read is the operand, and that address is the effective address.
- R5: With the long format, the memory flag at 1, `r2_i` at 0 and the indirect flag at 0, exactly one read is made at the second word. That address is the effective address.
- R6: With the long format, the memory flag at 1, `r2_i` nonzero and the indirect flag at 0, exactly one read is made at register `r2_i` plus the second word, modulo 2^16.
- R7: With the long format, the memory flag at 1, `r2_i` at 0 and the indirect flag at 1, the first read uses the second word as its address and returns a pointer. The second read uses that pointer as its address and returns the operand. The effective address is the pointer.
- R8: With the long format, the memory flag at 1, `r2_i` nonzero and the indirect flag at 1, the first read is at register `r2_i` plus the second word, modulo 2^16. The second read uses the returned pointer unmodified.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_valid_i` is seen. It is low whenever no resolution is in progress. Each read completes on the cycle in which `mem_valid_i` is high.
- R10: `done_o` is high for exactly one cycle per accepted start. For R1–R3 it is high in the cycle right after the start cycle.
- R11: A start request that arrives while a resolution is in progress is ignored. It does not change the result, the number of reads or the number of done pulses.
- R12: After reset, `done_o`, `mem_req_o`, `operand_o` and `ea_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a resolution (accepted only when idle) |
| fmt_i | input | 2 | 00 short constant, 01 short, 1x long |
| r2_i | input | 4 | Register index field |
| mem_i | input | 1 | Operand is in memory |
| indir_i | input | 1 | Indirect flag (long memory forms) |
| imm_i | input | 8 | Low byte of the instruction word |
| word2_i | input | 16 | Second instruction word |
| rf_addr_o | output | 4 | Register read port index |
| rf_data_i | input | 16 | Register read port data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | 16 | Memory read data |
| done_o | output | 1 | One-cycle completion strobe |
| operand_o | output | 16 | Resolved operand |
| ea_o | output | 16 | Effective address (0 for non-memory modes) |

## Verification
The hardest case to reach from the ports is a second start request that lands while the unit waits on memory between the pointer read and the operand read of an indirect mode. The bench models memory with a wait-cycle count set per operation, stretches an indirect resolution to several cycles, and pulses start with conflicting fields during the wait. It then checks the result, the read count and the done count of the first operation. Address wraparound is reached by pairing register 15 with large second words, so that the index sum overflows 16 bits both in indexed mode and in front of the pointer read.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [2:0] {
        MD_SHORTK = 3'd0,
        MD_REG    = 3'd1,
        MD_LONGK  = 3'd2,
        MD_REGIND = 3'd3,
        MD_DIR    = 3'd4,
        MD_IDX    = 3'd5,
        MD_IND    = 3'd6,
        MD_IDXIND = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_OPND = 2'd2
    } st_e;

endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
#(
    parameter int RIW = 4
) (
    input  logic [1:0]     fmt_i,
    input  logic [RIW-1:0] r2_i,
    input  logic           mem_i,
    input  logic           indir_i,
    output mode_e          mode_o,
    output logic           needs_mem_o,
    output logic           two_reads_o
);

    logic r2_zero;

    assign r2_zero = (r2_i == '0);

    always_comb begin
        mode_o = MD_SHORTK;
        if (fmt_i == 2'b00) begin
            mode_o = MD_SHORTK;
        end else if (fmt_i == 2'b01) begin
            mode_o = (mem_i && !r2_zero) ? MD_REGIND : MD_REG;
        end else if (!mem_i) begin
            mode_o = MD_LONGK;
        end else if (r2_zero) begin
            mode_o = indir_i ? MD_IND : MD_DIR;
        end else begin
            mode_o = indir_i ? MD_IDXIND : MD_IDX;
        end
    end

    assign needs_mem_o = !(mode_o == MD_SHORTK || mode_o == MD_REG || mode_o == MD_LONGK);
    assign two_reads_o = (mode_o == MD_IND) || (mode_o == MD_IDXIND);

endmodule

// File: rtl/opnd_agen.sv
module opnd_agen
    import opnd_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  mode_e          mode_i,
    input  logic [DW-1:0]  rf_data_i,
    input  logic [DW-1:0]  word2_i,
    input  logic [BW-1:0]  imm_i,
    output logic [DW-1:0]  addr_o,
    output logic [DW-1:0]  const_o
);

    localparam int PADW = DW - BW;

    logic [DW-1:0] idx_sum;

    assign idx_sum = rf_data_i + word2_i;

    always_comb begin
        addr_o = word2_i;
        unique case (mode_i)
            MD_REGIND:         addr_o = rf_data_i;
            MD_IDX, MD_IDXIND: addr_o = idx_sum;
            default:           addr_o = word2_i;
        endcase
    end

    always_comb begin
        const_o = word2_i;
        unique case (mode_i)
            MD_SHORTK: const_o = {{PADW{1'b0}}, imm_i};
            MD_REG:    const_o = rf_data_i;
            default:   const_o = word2_i;
        endcase
    end

endmodule

// File: rtl/opnd_resolve.sv
module opnd_resolve
    import opnd_pkg::*;
#(
    parameter int DW  = 16,
    parameter int RIW = 4,
    parameter int BW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [1:0]     fmt_i,
    input  logic [RIW-1:0] r2_i,
    input  logic           mem_i,
    input  logic           indir_i,
    input  logic [BW-1:0]  imm_i,
    input  logic [DW-1:0]  word2_i,
    output logic [RIW-1:0] rf_addr_o,
    input  logic [DW-1:0]  rf_data_i,
    output logic           mem_req_o,
    output logic [DW-1:0]  mem_addr_o,
    input  logic           mem_valid_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           done_o,
    output logic [DW-1:0]  operand_o,
    output logic [DW-1:0]  ea_o
);

    typedef struct packed {
        st_e           st;
        mode_e         mode;
        logic [DW-1:0] addr;
        logic [DW-1:0] operand;
        logic [DW-1:0] ea;
        logic          done;
    } regs_t;

    regs_t d, q;

    mode_e         dec_mode;
    logic          dec_mem;
    logic          dec_two;
    logic [DW-1:0] agen_addr;
    logic [DW-1:0] agen_const;
    st_e           st_q;
    mode_e         mode_q;

    opnd_decode #(.RIW(RIW)) decode_i (
        .fmt_i       (fmt_i),
        .r2_i        (r2_i),
        .mem_i       (mem_i),
        .indir_i     (indir_i),
        .mode_o      (dec_mode),
        .needs_mem_o (dec_mem),
        .two_reads_o (dec_two)
    );

    opnd_agen #(.DW(DW), .BW(BW)) agen_i (
        .mode_i    (dec_mode),
        .rf_data_i (rf_data_i),
        .word2_i   (word2_i),
        .imm_i     (imm_i),
        .addr_o    (agen_addr),
        .const_o   (agen_const)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.mode = dec_mode;
                    if (dec_mem) begin
                        d.addr = agen_addr;
                        d.st   = dec_two ? ST_PTR : ST_OPND;
                    end else begin
                        d.operand = agen_const;
                        d.ea      = '0;
                        d.done    = 1'b1;
                    end
                end
            end
            ST_PTR: begin
                if (mem_valid_i) begin
                    d.addr = mem_rdata_i;
                    d.st   = ST_OPND;
                end
            end
            ST_OPND: begin
                if (mem_valid_i) begin
                    d.operand = mem_rdata_i;
                    d.ea      = q.addr;
                    d.done    = 1'b1;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.mode    <= MD_SHORTK;
            q.addr    <= '0;
            q.operand <= '0;
            q.ea      <= '0;
            q.done    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rf_addr_o  = r2_i;
    assign mem_req_o  = (q.st != ST_IDLE);
    assign mem_addr_o = q.addr;
    assign done_o     = q.done;
    assign operand_o  = q.operand;
    assign ea_o       = q.ea;
    assign st_q       = q.st;
    assign mode_q     = q.mode;

endmodule

// File: rtl/opnd_resolve_chk.sv
module opnd_resolve_chk
    import opnd_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          mem_req_o,
    input logic [DW-1:0] mem_addr_o,
    input logic          mem_valid_i,
    input logic          done_o,
    input logic [DW-1:0] ea_o,
    input st_e           st_q,
    input mode_e         mode_q,
    input logic          dec_mem
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R9
    idle_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !mem_req_o);

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && start_i) |=> $stable(mode_q));

    // R10
    quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_i && !dec_mem) |=> (done_o && !mem_req_o));

    // R3
    ea_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (mode_q == MD_SHORTK || mode_q == MD_REG || mode_q == MD_LONGK))
        |-> (ea_o == '0));

endmodule

bind opnd_resolve opnd_resolve_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_valid_i (mem_valid_i),
    .done_o      (done_o),
    .ea_o        (ea_o),
    .st_q        (st_q),
    .mode_q      (mode_q),
    .dec_mem     (dec_mem)
);

// File: tb/opnd_resolve_tb.sv
`timescale 1ns/1ps
module opnd_resolve_tb_top;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [3:0]  r2;
        logic        ind;
        logic        mem;
        logic [7:0]  imm;
        logic [15:0] w2;
        logic [1:0]  lat;
        logic [1:0]  nrd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd0,  1'b0, 1'b0, 8'hC7, 16'h0000, 2'd0, 2'd0}, // R1
        '{2'd0, 4'd5,  1'b1, 1'b1, 8'hFF, 16'h7777, 2'd0, 2'd0}, // R1 fields ignored
        '{2'd1, 4'd3,  1'b0, 1'b0, 8'h00, 16'h0000, 2'd0, 2'd0}, // R2
        '{2'd1, 4'd0,  1'b0, 1'b1, 8'h00, 16'h0000, 2'd0, 2'd0}, // R2 zero index
        '{2'd2, 4'd0,  1'b0, 1'b0, 8'h00, 16'hBEEF, 2'd0, 2'd0}, // R3
        '{2'd3, 4'd6,  1'b1, 1'b0, 8'h00, 16'h1234, 2'd0, 2'd0}, // R3 fields ignored
        '{2'd1, 4'd2,  1'b0, 1'b1, 8'h00, 16'h0000, 2'd1, 2'd1}, // R4
        '{2'd2, 4'd0,  1'b0, 1'b1, 8'h00, 16'h0040, 2'd0, 2'd1}, // R5
        '{2'd2, 4'd4,  1'b0, 1'b1, 8'h00, 16'h0010, 2'd2, 2'd1}, // R6
        '{2'd2, 4'd15, 1'b0, 1'b1, 8'h00, 16'hF000, 2'd1, 2'd1}, // R6 wrap
        '{2'd2, 4'd0,  1'b1, 1'b1, 8'h00, 16'h0200, 2'd1, 2'd2}, // R7
        '{2'd2, 4'd1,  1'b1, 1'b1, 8'h00, 16'h0005, 2'd0, 2'd2}, // R8
        '{2'd2, 4'd15, 1'b1, 1'b1, 8'h00, 16'h1000, 2'd2, 2'd2}  // R8 wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  fmt_i = '0;
    logic [3:0]  r2_i = '0;
    logic        mem_i = 1'b0;
    logic        indir_i = 1'b0;
    logic [7:0]  imm_i = '0;
    logic [15:0] word2_i = '0;
    logic [3:0]  rf_addr_o;
    logic [15:0] rf_data_i;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic        done_o;
    logic [15:0] operand_o;
    logic [15:0] ea_o;

    int tests = 0;
    int fails = 0;
    bit ended = 0;
    int reads = 0;
    int dones = 0;
    int wcnt = 0;
    logic [1:0]  lat_cfg = '0;
    logic [15:0] rd_last = '0;
    logic [15:0] rd_prev = '0;

    always #4 clk = ~clk;

    opnd_resolve dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .fmt_i (fmt_i),
        .r2_i (r2_i), .mem_i (mem_i), .indir_i (indir_i), .imm_i (imm_i),
        .word2_i (word2_i), .rf_addr_o (rf_addr_o), .rf_data_i (rf_data_i),
        .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o),
        .mem_valid_i (mem_valid_i), .mem_rdata_i (mem_rdata_i),
        .done_o (done_o), .operand_o (operand_o), .ea_o (ea_o)
    );

    function automatic logic [15:0] fmem(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA55A;
    endfunction

    function automatic logic [15:0] rfv(input logic [3:0] i);
        return (16'h1000 * {12'd0, i}) + 16'h0123;
    endfunction

    assign rf_data_i = rfv(rf_addr_o);

    always @(negedge clk) begin
        if (done_o) dones <= dones + 1;
        if (mem_valid_i) begin
            mem_valid_i <= 1'b0;
            wcnt <= 0;
        end else if (mem_req_o) begin
            if (wcnt >= int'(lat_cfg)) begin
                mem_valid_i <= 1'b1;
                mem_rdata_i <= fmem(mem_addr_o);
                reads <= reads + 1;
                rd_prev <= rd_last;
                rd_last <= mem_addr_o;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_calc(input vec_t v, output logic [15:0] op, output logic [15:0] ea,
                            output logic [15:0] first);
        logic [15:0] a;
        logic [15:0] p;
        op = '0; ea = '0; first = '0;
        if (v.fmt == 2'b00) begin
            op = {8'h00, v.imm};
        end else if (v.fmt == 2'b01) begin
            if (v.mem && v.r2 != 0) begin
                a = rfv(v.r2); op = fmem(a); ea = a; first = a;
            end else begin
                op = rfv(v.r2);
            end
        end else if (!v.mem) begin
            op = v.w2;
        end else begin
            a = (v.r2 == 0) ? v.w2 : rfv(v.r2) + v.w2;
            first = a;
            if (v.ind) begin
                p = fmem(a); op = fmem(p); ea = p;
            end else begin
                op = fmem(a); ea = a;
            end
        end
    endtask

    task automatic run_op(input vec_t v, input string tag, output int cyc, output int nrd);
        int r0;
        @(negedge clk);
        fmt_i = v.fmt; r2_i = v.r2; mem_i = v.mem; indir_i = v.ind;
        imm_i = v.imm; word2_i = v.w2; lat_cfg = v.lat;
        r0 = reads;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_o) begin
            tests++; fails++;
            $display("FAIL %s timeout actual=no_done expected=done", tag);
        end
        nrd = reads - r0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!ended) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] eop, eea, efirst;
        int cyc, nrd, d0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 done", {15'd0, done_o}, 16'd0);
        check("R12 req", {15'd0, mem_req_o}, 16'd0);
        check("R12 operand", operand_o, 16'd0);
        check("R12 ea", ea_o, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ref_calc(VECS[i], eop, eea, efirst);
            run_op(VECS[i], $sformatf("vec%0d", i), cyc, nrd);
            check($sformatf("R1-8 operand vec%0d", i), operand_o, eop);
            check($sformatf("R1-8 ea vec%0d", i), ea_o, eea);
            check($sformatf("R9 reads vec%0d", i), 16'(nrd), {14'd0, VECS[i].nrd});
            if (VECS[i].nrd == 0)
                check($sformatf("R10 latency vec%0d", i), 16'(cyc), 16'd1);
            if (VECS[i].nrd == 2)
                check($sformatf("R7 R8 order vec%0d", i), rd_prev, efirst);
            @(negedge clk);
            // R10 single-cycle pulse
            check($sformatf("R10 pulse vec%0d", i), {15'd0, done_o}, 16'd0);
        end

        // R11 start while busy in an indirect resolution
        begin
            vec_t v;
            v = '{2'd2, 4'd1, 1'b1, 1'b1, 8'h00, 16'h0300, 2'd3, 2'd2};
            ref_calc(v, eop, eea, efirst);
            d0 = dones;
            @(negedge clk);
            fmt_i = v.fmt; r2_i = v.r2; mem_i = v.mem; indir_i = v.ind;
            word2_i = v.w2; lat_cfg = v.lat;
            nrd = reads;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (5) @(negedge clk);
            fmt_i = 2'b00; imm_i = 8'h11;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc = 0;
            while (!done_o && cyc < 60) begin
                @(negedge clk);
                cyc++;
            end
            check("R11 operand", operand_o, eop);
            check("R11 ea", ea_o, eea);
            check("R11 reads", 16'(reads - nrd), 16'd2);
            repeat (4) @(negedge clk);
            check("R11 done count", 16'(dones - d0), 16'd1);
            check("R11 idle req", {15'd0, mem_req_o}, 16'd0);
        end

        // R10 back-to-back non-memory starts each give one pulse
        d0 = dones;
        @(negedge clk);
        fmt_i = 2'b00; imm_i = 8'h5A; start_i = 1'b1;
        @(negedge clk);
        check("R10 b2b first", operand_o, 16'h005A);
        fmt_i = 2'b10; mem_i = 1'b0; word2_i = 16'hCAFE;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 b2b second", operand_o, 16'hCAFE);
        @(negedge clk);
        check("R10 b2b count", 16'(dones - d0), 16'd2);

        // R12 reset mid-operation
        @(negedge clk);
        fmt_i = 2'b10; mem_i = 1'b1; indir_i = 1'b1; r2_i = 4'd0;
        word2_i = 16'h0400; lat_cfg = 2'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 req after reset", {15'd0, mem_req_o}, 16'd0);
        check("R12 operand after reset", operand_o, 16'd0);
        check("R12 ea after reset", ea_o, 16'd0);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule